// File: doc/BRIEF.md
# Die Temperature Register Bank with Coherent Two-Byte Reads

This block is the register file that sits behind a byte-wide management-bus target reporting a die temperature. A host reaches it through a decoded register port: an 8-bit index, a read strobe, a write strobe and a write byte. Each access moves exactly one byte. The host never gets word or block transfers. Every temperature value is kept as two bytes. The integer byte counts whole degrees from 0 to 255. The fraction byte carries eighths of a degree in bits 7:5, so the full range is 0 to 255.875 in steps of 0.125. For example, integer 0x19 with fraction 0x20 is 25.125 degrees.

The on-die fabric supplies the live temperature through a valid/ready update port. The block accepts every beat: `upd_ready` is held high and never applies back-pressure, so a beat counts as taken on any clock edge where `upd_valid` is high. The host can program a high limit and a low limit, each in the same two-byte form. It can also read a status byte, a configuration byte and a revision byte.

The main job of the block is read coherency. The `rd_order` pin appears as bit 5 of the configuration byte and picks which half of the live temperature the host reads first. Reading that first half captures a snapshot. The following read of the other half returns the captured value, so fabric updates that arrive between the two byte reads cannot tear the pair.

Top module: `thermal_regbank`

## Requirements
- R1: After reset the live temperature reads 0x00/0x00, the limits read their parameter reset values, and `reg_rdata` is 0x00.
- R2: The index map is: 0x01 live integer, 0x10 live fraction, 0x07/0x13 high-limit integer/fraction, 0x08/0x14 low-limit integer/fraction, 0x02 status (reads 0x00), 0x03 configuration (bit 5 equals `rd_order`, other bits 0), 0xFF revision (reads `REV_ID`). Every other index reads 0x00.
- R3: Read data appears on `reg_rdata` at the clock edge that samples `reg_rd`. It then holds until the next read strobe, and writes do not change it.
- R4: A write to 0x07, 0x08, 0x13 or 0x14 updates that limit byte, and a later read returns it.
- R5: Fraction bytes carry eighths in bits 7:5. Bits 4:0 always read 0, and written values in bits 4:0 are dropped.
- R6: Writes to read-only or unmapped indexes (including 0x01, 0x10, 0x02, 0x03, 0xFF) change nothing.
- R7: An update beat (`upd_valid` high, `upd_ready` always high) loads `upd_int` and `upd_eighths` into the live temperature at that edge.
- R8: With `rd_order` = 0, a read of 0x01 captures the live fraction. The next read of 0x10 returns that captured fraction even if the fabric has updated since.
- R9: With `rd_order` = 1, a read of 0x10 captures the live integer. The next read of 0x01 returns that captured integer.
- R10: The partner read releases the snapshot. A second-half read made while no snapshot is held returns the live value.
- R11: A repeated first-half read made before the partner read refreshes the snapshot from the live value.
- R12: A change of `rd_order` discards any held snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_order | input | 1 | Read-order select: 0 integer first, 1 fraction first |
| upd_valid | input | 1 | Live temperature update beat valid |
| upd_ready | output | 1 | Update accepted (always 1) |
| upd_int | input | 8 | Update whole degrees |
| upd_eighths | input | 3 | Update eighths of a degree |
| reg_addr | input | 8 | Register index |
| reg_rd | input | 1 | Read strobe, one cycle per byte |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte, registered |

## Verification
The bench builds the block with `REV_ID` = 0x5A and with non-zero reset limits that differ from one another (high 90 + 6/8, low 12 + 2/8). This makes every mapped index hold a value that can be told apart from its neighbours and from the unmapped 0x00. With those values a sweep over all 256 indexes, both before and after a write of a distinct pattern to each index, exposes any decode error, a stuck reset or a leaked write. The live temperature is swept over a grid of integers and all eight eighths. The snapshot sequences run under both read orders, with fabric updates placed between the two halves, so that a stale, torn, unreleased or unrefreshed snapshot shows up as a wrong byte.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  localparam int BYTE_W    = 8;
  localparam int EIGHTHS_W = 3;
  localparam int PAD_W     = BYTE_W - EIGHTHS_W;
  localparam int ORDER_BIT = 5;
  localparam int NUM_LIM   = 2;

  // Host-visible indexes
  localparam logic [BYTE_W-1:0] IDX_LIVE_INT  = 8'h01;
  localparam logic [BYTE_W-1:0] IDX_STATUS    = 8'h02;
  localparam logic [BYTE_W-1:0] IDX_CONFIG    = 8'h03;
  localparam logic [BYTE_W-1:0] IDX_HI_INT    = 8'h07;
  localparam logic [BYTE_W-1:0] IDX_LO_INT    = 8'h08;
  localparam logic [BYTE_W-1:0] IDX_LIVE_FRAC = 8'h10;
  localparam logic [BYTE_W-1:0] IDX_HI_FRAC   = 8'h13;
  localparam logic [BYTE_W-1:0] IDX_LO_FRAC   = 8'h14;
  localparam logic [BYTE_W-1:0] IDX_REV       = 8'hFF;

  typedef struct packed {
    logic [BYTE_W-1:0]    whole;
    logic [EIGHTHS_W-1:0] eighths;
  } temp_t;
endpackage

// File: rtl/thermal_limit_reg.sv
module thermal_limit_reg
  import thermal_pkg::*;
#(
  parameter logic [BYTE_W-1:0]    RST_INT     = '0,
  parameter logic [EIGHTHS_W-1:0] RST_EIGHTHS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_int,
  input  logic              wr_frac,
  input  logic [BYTE_W-1:0] wdata,
  output temp_t             lim
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim.whole   <= RST_INT;
      lim.eighths <= RST_EIGHTHS;
    end else begin
      if (wr_int)  lim.whole   <= wdata;
      if (wr_frac) lim.eighths <= wdata[BYTE_W-1 -: EIGHTHS_W];
    end
  end
endmodule

// File: rtl/thermal_snapshot.sv
module thermal_snapshot
  import thermal_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  order,
  input  temp_t live,
  input  logic  capture,
  input  logic  release_i,
  output logic  held,
  output temp_t snap
);
  logic order_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q <= 1'b0;
      held    <= 1'b0;
      snap    <= '0;
    end else begin
      order_q <= order;
      if (capture) begin
        held <= 1'b1;
        snap <= live;
      end else if (release_i || (order != order_q)) begin
        held <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/thermal_regbank.sv
module thermal_regbank
  import thermal_pkg::*;
#(
  parameter logic [BYTE_W-1:0]    REV_ID         = 8'h04,
  parameter logic [BYTE_W-1:0]    HI_RST_INT     = 8'd95,
  parameter logic [EIGHTHS_W-1:0] HI_RST_EIGHTHS = 3'd0,
  parameter logic [BYTE_W-1:0]    LO_RST_INT     = 8'd5,
  parameter logic [EIGHTHS_W-1:0] LO_RST_EIGHTHS = 3'd4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_order,
  input  logic                 upd_valid,
  output logic                 upd_ready,
  input  logic [BYTE_W-1:0]    upd_int,
  input  logic [EIGHTHS_W-1:0] upd_eighths,
  input  logic [BYTE_W-1:0]    reg_addr,
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic [BYTE_W-1:0]    reg_wdata,
  output logic [BYTE_W-1:0]    reg_rdata
);
  temp_t live;
  temp_t snap;
  logic  snap_held;
  temp_t lim [NUM_LIM];
  logic [BYTE_W-1:0] hi_lim_int;
  logic [BYTE_W-1:0] rd_next;
  logic first_rd, second_rd;

  assign upd_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= '0;
    else if (upd_valid && upd_ready) begin
      live.whole   <= upd_int;
      live.eighths <= upd_eighths;
    end
  end

  for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
    localparam logic [BYTE_W-1:0] I_IDX = (g == 0) ? IDX_HI_INT : IDX_LO_INT;
    localparam logic [BYTE_W-1:0] F_IDX = (g == 0) ? IDX_HI_FRAC : IDX_LO_FRAC;
    thermal_limit_reg #(
      .RST_INT    ((g == 0) ? HI_RST_INT : LO_RST_INT),
      .RST_EIGHTHS((g == 0) ? HI_RST_EIGHTHS : LO_RST_EIGHTHS)
    ) u_lim (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_int (reg_wr && (reg_addr == I_IDX)),
      .wr_frac(reg_wr && (reg_addr == F_IDX)),
      .wdata  (reg_wdata),
      .lim    (lim[g])
    );
  end

  assign hi_lim_int = lim[0].whole;

  assign first_rd  = reg_rd && (reg_addr == (rd_order ? IDX_LIVE_FRAC : IDX_LIVE_INT));
  assign second_rd = reg_rd && (reg_addr == (rd_order ? IDX_LIVE_INT : IDX_LIVE_FRAC));

  thermal_snapshot u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .order    (rd_order),
    .live     (live),
    .capture  (first_rd),
    .release_i(second_rd),
    .held     (snap_held),
    .snap     (snap)
  );

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      IDX_LIVE_INT:  rd_next = (rd_order && snap_held) ? snap.whole : live.whole;
      IDX_LIVE_FRAC: rd_next = {((!rd_order && snap_held) ? snap.eighths : live.eighths),
                                {PAD_W{1'b0}}};
      IDX_STATUS:    rd_next = '0;
      IDX_CONFIG:    rd_next = BYTE_W'(rd_order) << ORDER_BIT;
      IDX_HI_INT:    rd_next = lim[0].whole;
      IDX_HI_FRAC:   rd_next = {lim[0].eighths, {PAD_W{1'b0}}};
      IDX_LO_INT:    rd_next = lim[1].whole;
      IDX_LO_FRAC:   rd_next = {lim[1].eighths, {PAD_W{1'b0}}};
      IDX_REV:       rd_next = REV_ID;
      default:       rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/thermal_regbank_chk.sv
module thermal_regbank_chk
  import thermal_pkg::*;
#(
  parameter logic [BYTE_W-1:0] REV_ID = 8'h04
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_rd,
  input logic                 reg_wr,
  input logic [BYTE_W-1:0]    reg_addr,
  input logic [BYTE_W-1:0]    reg_wdata,
  input logic [BYTE_W-1:0]    reg_rdata,
  input logic                 upd_valid,
  input logic [BYTE_W-1:0]    live_int,
  input logic [EIGHTHS_W-1:0] live_eighths,
  input logic                 snap_held,
  input logic [BYTE_W-1:0]    snap_int,
  input logic [EIGHTHS_W-1:0] snap_eighths,
  input logic [BYTE_W-1:0]    hi_lim_int
);
  logic is_frac, is_mapped;
  assign is_frac = (reg_addr == IDX_LIVE_FRAC) || (reg_addr == IDX_HI_FRAC) ||
                   (reg_addr == IDX_LO_FRAC);
  assign is_mapped = is_frac || (reg_addr == IDX_LIVE_INT) || (reg_addr == IDX_STATUS) ||
                     (reg_addr == IDX_CONFIG) || (reg_addr == IDX_HI_INT) ||
                     (reg_addr == IDX_LO_INT) || (reg_addr == IDX_REV);

  // R5
  frac_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && is_frac) |=> (reg_rdata[PAD_W-1:0] == '0));

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !is_mapped) |=> (reg_rdata == '0));

  // R2
  revision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == IDX_REV) |=> (reg_rdata == REV_ID));

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  // R6
  live_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(live_int) && $stable(live_eighths)));

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_held && !reg_rd) |=> ($stable(snap_int) && $stable(snap_eighths)));

  // R4
  limit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == IDX_HI_INT) |=> (hi_lim_int == $past(reg_wdata)));
endmodule

bind thermal_regbank thermal_regbank_chk #(.REV_ID(REV_ID)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rd      (reg_rd),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .upd_valid   (upd_valid),
  .live_int    (live.whole),
  .live_eighths(live.eighths),
  .snap_held   (snap_held),
  .snap_int    (snap.whole),
  .snap_eighths(snap.eighths),
  .hi_lim_int  (hi_lim_int)
);

// File: tb/test_thermal_regbank.sv
module test_thermal_regbank;
  localparam logic [7:0] REV  = 8'h5A;
  localparam logic [7:0] HI_I = 8'd90;
  localparam logic [2:0] HI_E = 3'd6;
  localparam logic [7:0] LO_I = 8'd12;
  localparam logic [2:0] LO_E = 3'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_order = 1'b0;
  logic upd_valid = 1'b0;
  logic upd_ready;
  logic [7:0] upd_int = '0;
  logic [2:0] upd_eighths = '0;
  logic [7:0] reg_addr = '0;
  logic reg_rd = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [7:0] m_hi_i, m_lo_i, m_int;
  logic [2:0] m_hi_e, m_lo_e, m_e;

  always #10 clk = ~clk;

  thermal_regbank #(
    .REV_ID(REV), .HI_RST_INT(HI_I), .HI_RST_EIGHTHS(HI_E),
    .LO_RST_INT(LO_I), .LO_RST_EIGHTHS(LO_E)
  ) i_thermal_regbank (
    .clk(clk), .rst_n(rst_n), .rd_order(rd_order),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_int(upd_int),
    .upd_eighths(upd_eighths), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic upd(input logic [7:0] i, input logic [2:0] e);
    @(negedge clk);
    upd_int = i; upd_eighths = e; upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    m_int = i; m_e = e;
  endtask

  function automatic logic [7:0] expect_plain(input logic [7:0] a);
    case (a)
      8'h01: return m_int;
      8'h10: return {m_e, 5'b0};
      8'h03: return {2'b0, rd_order, 5'b0};
      8'h07: return m_hi_i;
      8'h13: return {m_hi_e, 5'b0};
      8'h08: return m_lo_i;
      8'h14: return {m_lo_e, 5'b0};
      8'hFF: return REV;
      default: return 8'h00;
    endcase
  endfunction

  task automatic sweep_all(input string req);
    logic [7:0] d;
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), d);
      check(req, d, expect_plain(8'(a)));
    end
  endtask

  initial begin
    logic [7:0] d;
    m_hi_i = HI_I; m_hi_e = HI_E; m_lo_i = LO_I; m_lo_e = LO_E;
    m_int = '0; m_e = '0;
    repeat (3) @(negedge clk);
    // R1: reset value of read port
    check("R1 rdata reset", reg_rdata, 8'h00);
    rst_n = 1'b1;
    // R1 R2: whole map after reset
    sweep_all("R1/R2 reset map");
    check("R7 ready", {7'b0, upd_ready}, 8'h01);

    // R4 R6: write a distinct pattern to every index, then re-read
    for (int a = 0; a < 256; a++) begin
      logic [7:0] p;
      p = 8'(a) ^ 8'hA5;
      wr(8'(a), p);
      case (8'(a))
        8'h07: m_hi_i = p;
        8'h08: m_lo_i = p;
        8'h13: m_hi_e = p[7:5];
        8'h14: m_lo_e = p[7:5];
        default: ;
      endcase
    end
    sweep_all("R4/R6 after write sweep");

    // R5: every value into both limit fraction bytes
    for (int v = 0; v < 256; v++) begin
      wr(8'h13, 8'(v));
      rd(8'h13, d);
      check("R5 hi frac", d, 8'(v) & 8'hE0);
      wr(8'h14, 8'(255 - v));
      rd(8'h14, d);
      check("R5 lo frac", d, 8'(255 - v) & 8'hE0);
    end

    // R7: live update grid
    for (int i = 0; i < 256; i += 17) begin
      for (int e = 0; e < 8; e++) begin
        upd(8'(i), 3'(e));
        rd(8'h01, d); check("R7 live int", d, 8'(i));
        rd(8'h10, d); check("R7 live frac", d, {3'(e), 5'b0});
      end
    end

    // R8: integer first, fraction frozen across an update
    rd_order = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      upd(8'h19 + 8'(k), 3'(k));
      rd(8'h01, d); check("R8 int", d, 8'h19 + 8'(k));
      upd(8'h40 + 8'(k), 3'(7 - k));
      rd(8'h10, d); check("R8 frozen frac", d, {3'(k), 5'b0});
      // R10: released, live now
      rd(8'h10, d); check("R10 live frac after release", d, {3'(7 - k), 5'b0});
    end

    // R9: fraction first, integer frozen
    rd_order = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h03, d); check("R2 config order bit", d, 8'h20);
    for (int k = 0; k < 8; k++) begin
      upd(8'd40 + 8'(k), 3'(k));
      rd(8'h10, d); check("R9 frac", d, {3'(k), 5'b0});
      upd(8'd200 - 8'(k), 3'(7 - k));
      rd(8'h01, d); check("R9 frozen int", d, 8'd40 + 8'(k));
      rd(8'h01, d); check("R10 live int after release", d, 8'd200 - 8'(k));
    end

    // R11: refresh on repeated first-half read
    rd_order = 1'b0;
    repeat (2) @(negedge clk);
    upd(8'd10, 3'd2);
    rd(8'h01, d);
    upd(8'd11, 3'd4);
    rd(8'h01, d); check("R11 int", d, 8'd11);
    upd(8'd12, 3'd6);
    rd(8'h10, d); check("R11 refreshed frac", d, 8'h80);

    // R12: order change drops the snapshot
    upd(8'd20, 3'd1);
    rd(8'h01, d);
    upd(8'd20, 3'd3);
    @(negedge clk); rd_order = 1'b1;
    repeat (2) @(negedge clk); rd_order = 1'b0;
    repeat (2) @(negedge clk);
    rd(8'h10, d); check("R12 dropped snapshot", d, 8'h60);

    // R3: read data holds across idle cycles and writes
    rd(8'hFF, d);
    wr(8'h07, 8'h33); m_hi_i = 8'h33;
    repeat (3) @(negedge clk);
    check("R3 rdata hold", reg_rdata, REV);
    rd(8'h07, d); check("R4 hi int", d, 8'h33);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule